// File: doc/BRIEF.md
# Automatic RTS/CTS Flow Controller

This block handles hardware flow control for a single UART channel. On the transmit side it watches an active-low clear-to-send input and tells the framer whether it may start the next character. On the receive side it drives an active-low request-to-send output from the receive FIFO fill level, so the far end stops sending before the FIFO overflows.

The two automatic functions have separate enables. The receive side uses a pair of 4-bit threshold fields, each scaled by four. RTS is withdrawn when the fill level reaches the halt level and asserted again once the level falls to the resume level. The gap between the two levels gives hysteresis. When both threshold fields are zero, the FIFO trigger level takes their place. With automatic RTS turned off, a software-controlled bit drives the pin directly.

The clear-to-send input passes through a synchroniser. Its current state and a sticky change flag are reported as status bits. A character already in progress is never cut short; only the start of the next one is held.

Top module: `uart_flow_ctrl`

## Requirements
- R1: While reset is asserted, and before the first clock edge after it, rts_n is 1, tx_allowed is 0, cts_state is 0 and cts_delta is 0.
- R2: With cts_auto_en at 0, tx_allowed is 1 one cycle later, whatever the level of cts_n_pin.
- R3: With cts_auto_en at 1 and tx_active at 0, tx_allowed follows the inverted cts_n_pin. A pin change shows on tx_allowed after exactly three rising clock edges: two synchroniser stages and one output register.
- R4: While tx_active is 1, tx_allowed is held at 1 even if CTS goes inactive. The hold ends on the cycle after tx_active falls.
- R5: With rts_auto_en at 1 and a non-zero threshold register, rts_n becomes 1 one cycle after rx_count is greater than or equal to 4*halt_thr.
- R6: With rts_auto_en at 1, rts_n becomes 0 one cycle after rx_count is less than or equal to 4*resume_thr. Between the two levels, rts_n keeps its previous value. The threshold rule requires halt_thr > resume_thr.
- R7: When halt_thr and resume_thr are both zero, the halt level is fcr_trig and the resume level is fcr_trig-1, floored at zero. The trigger level must be at least 1.
- R8: With rts_auto_en at 0, rts_n equals the inverse of rts_manual one cycle later, and rx_count has no effect on it.
- R9: cts_state is 1 when the synchronised CTS is low (active). cts_delta is set on the same edge that cts_state changes, and is cleared by cts_delta_clr; a new change wins over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cts_auto_en | input | 1 | Enables automatic CTS gating of transmission |
| rts_auto_en | input | 1 | Enables automatic RTS from the receive fill level |
| halt_thr | input | 4 | Halt level in units of four characters |
| resume_thr | input | 4 | Resume level in units of four characters |
| fcr_trig | input | 7 | Fallback trigger level in characters |
| rx_count | input | 7 | Current receive FIFO fill level |
| cts_n_pin | input | 1 | Clear-to-send pin, active low, asynchronous |
| rts_manual | input | 1 | Software RTS control; 1 drives rts_n low when automatic RTS is off |
| tx_active | input | 1 | Framer is in the middle of a character |
| cts_delta_clr | input | 1 | Clears the CTS change flag |
| rts_n | output | 1 | Request-to-send pin, active low |
| tx_allowed | output | 1 | Framer may start a new character |
| cts_state | output | 1 | Synchronised CTS, 1 = active |
| cts_delta | output | 1 | Sticky CTS change flag |

## Verification
On every cycle the assertions check several one-cycle relations. With CTS gating off, or with a character in progress, transmit permission stays granted. The halt and resume rules drive the RTS pin correctly whenever the programmed levels are legal. With automatic RTS off, the manual bit reaches the pin. Any edge on the reported CTS state raises the change flag. Only the bench's scenarios can show the exact three-edge synchroniser latency and the memory of the hysteresis band between the two levels. They also cover the fallback to the trigger level and the priority of a new change over a clear.

// File: rtl/flow_pkg.sv
package flow_pkg;

    // Receive-side state: hysteresis latch and the registered pin
    typedef struct packed {
        logic on;
        logic pin_n;
    } rts_state_t;

    // Transmit-side state: last synchronised level, grant and change flag
    typedef struct packed {
        logic prev_n;
        logic allowed;
        logic delta;
    } cts_state_t;

endpackage

// File: rtl/flow_sync.sv
module flow_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = din;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/flow_thresh.sv
module flow_thresh #(
    parameter int CNT_W     = 7,
    parameter int THR_W     = 4,
    parameter int THR_SHIFT = 2
) (
    input  logic [THR_W-1:0] halt_thr,
    input  logic [THR_W-1:0] resume_thr,
    input  logic [CNT_W-1:0] fcr_trig,
    output logic [CNT_W-1:0] eff_halt,
    output logic [CNT_W-1:0] eff_resume
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic             use_fallback;
    logic [CNT_W-1:0] halt_scaled, resume_scaled, trig_less;

    always_comb begin
        use_fallback  = (halt_thr == '0) && (resume_thr == '0);
        halt_scaled   = CNT_W'(halt_thr) << THR_SHIFT;
        resume_scaled = CNT_W'(resume_thr) << THR_SHIFT;
        trig_less     = (fcr_trig == '0) ? '0 : (fcr_trig - ONE);
        eff_halt      = use_fallback ? fcr_trig  : halt_scaled;
        eff_resume    = use_fallback ? trig_less : resume_scaled;
    end
endmodule

// File: rtl/flow_rts_ctrl.sv
module flow_rts_ctrl
    import flow_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_en,
    input  logic             manual,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] eff_halt,
    input  logic [CNT_W-1:0] eff_resume,
    output logic             rts_n
);
    rts_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Hysteresis latch keeps tracking even while auto mode is off
        if (st_q.on && (count >= eff_halt))
            st_d.on = 1'b0;
        else if (!st_q.on && (count <= eff_resume))
            st_d.on = 1'b1;
        st_d.pin_n = auto_en ? ~st_d.on : ~manual;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{on: 1'b0, pin_n: 1'b1};
        else        st_q <= st_d;
    end

    assign rts_n = st_q.pin_n;
endmodule

// File: rtl/flow_cts_gate.sv
module flow_cts_gate
    import flow_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic tx_active,
    input  logic cts_sync_n,
    input  logic delta_clr,
    output logic tx_allowed,
    output logic cts_state,
    output logic cts_delta
);
    cts_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.prev_n  = cts_sync_n;
        st_d.allowed = !auto_en || tx_active || !cts_sync_n;
        if (cts_sync_n != st_q.prev_n) st_d.delta = 1'b1;
        else if (delta_clr)            st_d.delta = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{prev_n: 1'b1, allowed: 1'b0, delta: 1'b0};
        else        st_q <= st_d;
    end

    assign tx_allowed = st_q.allowed;
    assign cts_state  = ~st_q.prev_n;
    assign cts_delta  = st_q.delta;
endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl #(
    parameter int CNT_W       = 7,
    parameter int THR_W       = 4,
    parameter int THR_SHIFT   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cts_auto_en,
    input  logic             rts_auto_en,
    input  logic [THR_W-1:0] halt_thr,
    input  logic [THR_W-1:0] resume_thr,
    input  logic [CNT_W-1:0] fcr_trig,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             cts_n_pin,
    input  logic             rts_manual,
    input  logic             tx_active,
    input  logic             cts_delta_clr,
    output logic             rts_n,
    output logic             tx_allowed,
    output logic             cts_state,
    output logic             cts_delta
);
    logic [CNT_W-1:0] eff_halt, eff_resume;
    logic             cts_sync_n;

    flow_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (cts_n_pin),
        .dout (cts_sync_n)
    );

    flow_thresh #(.CNT_W(CNT_W), .THR_W(THR_W), .THR_SHIFT(THR_SHIFT)) u_thresh (
        .halt_thr  (halt_thr),
        .resume_thr(resume_thr),
        .fcr_trig  (fcr_trig),
        .eff_halt  (eff_halt),
        .eff_resume(eff_resume)
    );

    flow_rts_ctrl #(.CNT_W(CNT_W)) u_rts (
        .clk       (clk),
        .rst_n     (rst_n),
        .auto_en   (rts_auto_en),
        .manual    (rts_manual),
        .count     (rx_count),
        .eff_halt  (eff_halt),
        .eff_resume(eff_resume),
        .rts_n     (rts_n)
    );

    flow_cts_gate u_cts (
        .clk       (clk),
        .rst_n     (rst_n),
        .auto_en   (cts_auto_en),
        .tx_active (tx_active),
        .cts_sync_n(cts_sync_n),
        .delta_clr (cts_delta_clr),
        .tx_allowed(tx_allowed),
        .cts_state (cts_state),
        .cts_delta (cts_delta)
    );
endmodule

// File: rtl/uart_flow_ctrl_chk.sv
module uart_flow_ctrl_chk #(
    parameter int CNT_W     = 7,
    parameter int THR_W     = 4,
    parameter int THR_SHIFT = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cts_auto_en,
    input logic             rts_auto_en,
    input logic [THR_W-1:0] halt_thr,
    input logic [THR_W-1:0] resume_thr,
    input logic [CNT_W-1:0] rx_count,
    input logic             rts_manual,
    input logic             tx_active,
    input logic             rts_n,
    input logic             tx_allowed,
    input logic             cts_state,
    input logic             cts_delta
);
    logic [CNT_W-1:0] halt_lvl, resume_lvl;
    logic             legal_thr;

    assign halt_lvl   = CNT_W'(halt_thr) << THR_SHIFT;
    assign resume_lvl = CNT_W'(resume_thr) << THR_SHIFT;
    assign legal_thr  = (halt_thr > resume_thr);

    a_r2_cts_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        !cts_auto_en |=> tx_allowed);

    a_r4_char_hold: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active |=> tx_allowed);

    a_r5_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_auto_en && legal_thr && rx_count >= halt_lvl) |=> rts_n);

    a_r6_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_auto_en && legal_thr && rx_count <= resume_lvl) |=> !rts_n);

    a_r8_manual: assert property (@(posedge clk) disable iff (!rst_n)
        !rts_auto_en |=> (rts_n == !$past(rts_manual)));

    a_r9_delta_set: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cts_state) || $fell(cts_state)) |-> cts_delta);
endmodule

bind uart_flow_ctrl uart_flow_ctrl_chk #(
    .CNT_W(CNT_W), .THR_W(THR_W), .THR_SHIFT(THR_SHIFT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cts_auto_en(cts_auto_en),
    .rts_auto_en(rts_auto_en),
    .halt_thr   (halt_thr),
    .resume_thr (resume_thr),
    .rx_count   (rx_count),
    .rts_manual (rts_manual),
    .tx_active  (tx_active),
    .rts_n      (rts_n),
    .tx_allowed (tx_allowed),
    .cts_state  (cts_state),
    .cts_delta  (cts_delta)
);

// File: tb/uart_flow_ctrl_test.sv
module uart_flow_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cts_auto_en = 1'b1;
    logic       rts_auto_en = 1'b1;
    logic [3:0] halt_thr = 4'd8;
    logic [3:0] resume_thr = 4'd4;
    logic [6:0] fcr_trig = 7'd8;
    logic [6:0] rx_count = 7'd0;
    logic       cts_n_pin = 1'b1;
    logic       rts_manual = 1'b0;
    logic       tx_active = 1'b0;
    logic       cts_delta_clr = 1'b0;
    logic       rts_n, tx_allowed, cts_state, cts_delta;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    uart_flow_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cts_auto_en(cts_auto_en), .rts_auto_en(rts_auto_en),
        .halt_thr(halt_thr), .resume_thr(resume_thr), .fcr_trig(fcr_trig),
        .rx_count(rx_count), .cts_n_pin(cts_n_pin), .rts_manual(rts_manual),
        .tx_active(tx_active), .cts_delta_clr(cts_delta_clr), .rts_n(rts_n),
        .tx_allowed(tx_allowed), .cts_state(cts_state), .cts_delta(cts_delta)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic t_reset;
        check("R1", "rts_n in reset", rts_n, 1'b1);
        check("R1", "tx_allowed in reset", tx_allowed, 1'b0);
        check("R1", "cts_state in reset", cts_state, 1'b0);
        check("R1", "cts_delta in reset", cts_delta, 1'b0);
        rst_n = 1'b1;
        check("R1", "rts_n before first edge", rts_n, 1'b1);
        tick(1);
        check("R6", "rts_n low with empty fifo", rts_n, 1'b0);
    endtask

    task automatic t_cts_bypass;
        cts_auto_en = 1'b0;
        tick(1);
        check("R2", "tx_allowed with gating off", tx_allowed, 1'b1);
        cts_auto_en = 1'b1;
        tick(1);
        check("R3", "tx_allowed with CTS inactive", tx_allowed, 1'b0);
    endtask

    task automatic t_cts_sync;
        cts_n_pin = 1'b0;
        tick(2);
        check("R3", "tx_allowed after two edges", tx_allowed, 1'b0);
        tick(1);
        check("R3", "tx_allowed after three edges", tx_allowed, 1'b1);
        check("R9", "cts_state active", cts_state, 1'b1);
        check("R9", "cts_delta set", cts_delta, 1'b1);
        cts_delta_clr = 1'b1;
        tick(1);
        cts_delta_clr = 1'b0;
        check("R9", "cts_delta cleared", cts_delta, 1'b0);
    endtask

    task automatic t_mid_char;
        tx_active = 1'b1;
        cts_n_pin = 1'b1;
        tick(4);
        check("R4", "tx_allowed held mid-character", tx_allowed, 1'b1);
        check("R9", "cts_state inactive", cts_state, 1'b0);
        tx_active = 1'b0;
        tick(1);
        check("R4", "tx_allowed drops after character", tx_allowed, 1'b0);
        // change and clear in the same cycle: change wins
        cts_delta_clr = 1'b1;
        cts_n_pin = 1'b0;
        tick(3);
        check("R9", "change wins over clear", cts_delta, 1'b1);
        tick(1);
        check("R9", "clear after change", cts_delta, 1'b0);
        cts_delta_clr = 1'b0;
    endtask

    task automatic set_count(input int c, input logic exp, input string req);
        rx_count = 7'(c);
        tick(1);
        check(req, $sformatf("rts_n at count %0d", c), rts_n, exp);
    endtask

    task automatic t_hysteresis;
        halt_thr = 4'd8; resume_thr = 4'd4;
        set_count(31, 1'b0, "R5");
        set_count(32, 1'b1, "R5");
        set_count(20, 1'b1, "R6");
        set_count(16, 1'b0, "R6");
        set_count(20, 1'b0, "R6");
        set_count(40, 1'b1, "R5");
    endtask

    task automatic t_fallback;
        halt_thr = 4'd0; resume_thr = 4'd0; fcr_trig = 7'd8;
        set_count(0, 1'b0, "R7");
        set_count(8, 1'b1, "R7");
        set_count(8, 1'b1, "R7");
        set_count(7, 1'b0, "R7");
        fcr_trig = 7'd20;
        set_count(19, 1'b0, "R7");
        set_count(20, 1'b1, "R7");
    endtask

    task automatic t_manual;
        halt_thr = 4'd8; resume_thr = 4'd4;
        rts_auto_en = 1'b0;
        rts_manual = 1'b1;
        set_count(60, 1'b0, "R8");
        rts_manual = 1'b0;
        tick(1);
        check("R8", "rts_n follows manual bit", rts_n, 1'b1);
        rts_manual = 1'b1;
        set_count(0, 1'b0, "R8");
        rx_count = 7'd60;
        rts_auto_en = 1'b1;
        tick(1);
        check("R5", "auto resumes at full fifo", rts_n, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_cts_bypass();
        t_cts_sync();
        t_mid_char();
        t_hysteresis();
        t_fallback();
        t_manual();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule